// File: doc/BRIEF.md
# Buck Phase Gate Sequencer

This block is the digital sequencer for one synchronous step-down phase. It receives strobes from the PWM logic (a cycle-start strobe and a PWM-off strobe) and flags from the analog comparators: a sense flag that says the low-side gate has fully discharged, and a valley over-current flag. From these it drives the high-side and low-side gate commands so that the two switches never conduct together.

The high side turns on only after the low-side gate is confirmed off. The low side turns on a fixed number of clock cycles after the high side turns off. At a cycle start, an over-current reading skips the high-side pulse and keeps the synchronous rectifier on. If the discharge sense never arrives, a watchdog stops the sequence and raises a fault.

Enable, undervoltage lockout and thermal shutdown each force both gates low and return the sequencer to idle. Both gate commands and the fault flag come from registers.

Top module: `buck_gate_seq`

## Requirements
- R1: `gate_hi` and `gate_lo` are never high in the same cycle. Outside dead-time and waiting intervals, exactly one of them is high.
- R2: `gate_hi` rises only on the clock edge at which `lo_off_sense` is sampled high. This happens only while the sequencer waits for the sense with both gates low, and it takes one cycle.
- R3: When `gate_hi` falls because of `pwm_off`, `gate_lo` rises exactly `DT_CYC` clock edges later (default 3, which is 30 ns at 100 MHz). Both gates stay low in between.
- R4: A `cyc_start` strobe while idle or while the low side is on works as follows. With `valley_oc` high, `gate_lo` stays on (or is turned on) and no high-side pulse starts. With `valley_oc` low, `gate_lo` falls on the next edge and the sense wait begins. A `cyc_start` while the high side is on is ignored.
- R5: When `uvlo` is high at an edge, both gates are low after that edge and the sequencer returns to idle. Idle means the low side stays off until a `cyc_start` is seen.
- R6: When `therm` is high at an edge, both gates are low after that edge and the sequencer returns to idle.
- R7: When `en` is low at an edge, both gates and `sense_fault` are low after that edge. Any `cyc_start` is ignored while `en` is low.
- R8: If `lo_off_sense` is not seen within `TMO_CYC` cycles (default 64) of entering the sense wait, `sense_fault` rises on the `TMO_CYC`-th edge. After that, `gate_hi` stays low whatever the inputs do, until the block is disabled or reset.
- R9: A `pwm_off` strobe during the sense wait cancels the pulse: `gate_lo` returns high on the next edge and `gate_hi` stays low. This holds even if `lo_off_sense` is high in the same cycle.
- R10: After synchronous reset (`rst` high), `gate_hi`, `gate_lo` and `sense_fault` are low and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable, high to run |
| uvlo | input | 1 | Undervoltage lockout active |
| therm | input | 1 | Thermal shutdown active |
| cyc_start | input | 1 | Start-of-cycle strobe |
| pwm_off | input | 1 | PWM pulse-end strobe |
| lo_off_sense | input | 1 | Low-side gate fully discharged |
| valley_oc | input | 1 | Valley current above limit |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |
| sense_fault | output | 1 | Discharge-sense timeout fault |

## Verification
Two events can coincide during the sense wait: the pulse-cancel strobe and the discharge sense. The bench drives `pwm_off` and `lo_off_sense` high in the same cycle and expects the cancel to win. That means `gate_lo` high and `gate_hi` low after the edge, with no high-side pulse at all. A second collision is a lockout input arriving while the high side is on, or `cyc_start` arriving while disabled. Both are judged by requiring both gates low on the following edge.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // both gates low, waiting for a cycle start
    ST_LO_ON = 3'd1,  // synchronous rectifier conducting
    ST_WAIT  = 3'd2,  // low commanded off, waiting for discharge sense
    ST_HI_ON = 3'd3,  // high side conducting
    ST_DEAD  = 3'd4,  // fixed delay before low side turns on
    ST_FAULT = 3'd5   // discharge sense never arrived
  } gseq_state_e;

endpackage

// File: rtl/gseq_counter.sv
module gseq_counter #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,   // count while high, clear while low
  output logic hit    // count has reached LIMIT-1
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  assign hit = run && (cnt == LAST);

  // R3 / R8: the interval counter never passes its terminal value
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R3 / R8: a stopped counter restarts from zero on the next run
  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0);

endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
  import gseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic uvlo,
  input  logic therm,
  input  logic cyc_start,
  input  logic pwm_off,
  input  logic lo_off_sense,
  input  logic valley_oc,
  input  logic dt_hit,
  input  logic to_hit,
  output logic dt_run,
  output logic to_run,
  output logic gate_hi,
  output logic gate_lo,
  output logic fault
);

  gseq_state_e state, nxt;
  logic inhibit;

  assign inhibit = !en || uvlo || therm;
  assign dt_run  = (state == ST_DEAD);
  assign to_run  = (state == ST_WAIT);

  always_comb begin
    nxt = state;
    if (inhibit) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE, ST_LO_ON:
          if (cyc_start) nxt = valley_oc ? ST_LO_ON : ST_WAIT;
        ST_WAIT:
          if (pwm_off)           nxt = ST_LO_ON;  // cancel wins
          else if (lo_off_sense) nxt = ST_HI_ON;
          else if (to_hit)       nxt = ST_FAULT;
        ST_HI_ON:
          if (pwm_off) nxt = ST_DEAD;
        ST_DEAD:
          if (dt_hit) nxt = ST_LO_ON;
        ST_FAULT:
          nxt = ST_FAULT;
        default:
          nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      fault   <= 1'b0;
    end else begin
      state   <= nxt;
      gate_hi <= (nxt == ST_HI_ON);
      gate_lo <= (nxt == ST_LO_ON);
      fault   <= (nxt == ST_FAULT);
    end
  end

  // R1: no shoot-through
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));

  // R2: high side starts only on a sampled discharge sense
  p_hi_needs_sense_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_hi) |-> $past(lo_off_sense) && !$past(gate_lo));

  // R3: low side stays off for at least two edges after high side falls
  p_dead_edge1_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_hi) |-> !gate_lo);
  p_dead_edge2_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_hi) |=> !gate_lo);

  // R4: over-current at cycle start keeps the rectifier on
  p_oc_skip_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LO_ON && cyc_start && valley_oc && !inhibit)
      |=> gate_lo && !gate_hi);

  // R5: undervoltage forces both gates low
  p_uvlo_off_r5: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> !gate_hi && !gate_lo);

  // R6: thermal shutdown forces both gates low
  p_therm_off_r6: assert property (@(posedge clk) disable iff (rst)
    therm |=> !gate_hi && !gate_lo);

  // R7: disable clears gates and fault
  p_disable_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !gate_hi && !gate_lo && !fault);

  // R8: a fault keeps the high side off
  p_fault_hi_off_r8: assert property (@(posedge clk) disable iff (rst)
    fault |-> !gate_hi);

  // R9: cancel in the wait state returns to the rectifier
  p_cancel_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && pwm_off && !inhibit) |=> gate_lo && !gate_hi);

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
  parameter int DT_CYC  = 3,
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic uvlo,
  input  logic therm,
  input  logic cyc_start,
  input  logic pwm_off,
  input  logic lo_off_sense,
  input  logic valley_oc,
  output logic gate_hi,
  output logic gate_lo,
  output logic sense_fault
);

  logic dt_run, dt_hit, to_run, to_hit;

  gseq_counter #(.LIMIT(DT_CYC)) u_dead_cnt (
    .clk (clk),
    .rst (rst),
    .run (dt_run),
    .hit (dt_hit)
  );

  gseq_counter #(.LIMIT(TMO_CYC)) u_tmo_cnt (
    .clk (clk),
    .rst (rst),
    .run (to_run),
    .hit (to_hit)
  );

  gseq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .uvlo         (uvlo),
    .therm        (therm),
    .cyc_start    (cyc_start),
    .pwm_off      (pwm_off),
    .lo_off_sense (lo_off_sense),
    .valley_oc    (valley_oc),
    .dt_hit       (dt_hit),
    .to_hit       (to_hit),
    .dt_run       (dt_run),
    .to_run       (to_run),
    .gate_hi      (gate_hi),
    .gate_lo      (gate_lo),
    .fault        (sense_fault)
  );

  // R10: outputs are low on the first edge after reset
  p_reset_low_r10: assert property (@(posedge clk)
    $past(rst) |-> !gate_hi && !gate_lo && !sense_fault);

endmodule

// File: tb/buck_gate_seq_bench.sv
module buck_gate_seq_bench;

  logic clk = 1'b0;
  logic rst, en, uvlo, therm, cyc_start, pwm_off, lo_off_sense, valley_oc;
  logic gate_hi, gate_lo, sense_fault;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  buck_gate_seq u_buck_gate_seq (
    .clk(clk), .rst(rst), .en(en), .uvlo(uvlo), .therm(therm),
    .cyc_start(cyc_start), .pwm_off(pwm_off), .lo_off_sense(lo_off_sense),
    .valley_oc(valley_oc), .gate_hi(gate_hi), .gate_lo(gate_lo),
    .sense_fault(sense_fault)
  );

  // Vector fields: [13:10] requirement number,
  // [9:3] {en,uvlo,therm,cyc_start,pwm_off,lo_off_sense,valley_oc},
  // [2:0] expected {gate_hi,gate_lo,sense_fault} after the edge
  localparam int NV = 26;
  localparam logic [13:0] VEC [NV] = '{
    {4'd4,  10'b1001001_010},  // R4 start with over-current: rectifier on
    {4'd1,  10'b1000000_010},  // R1 rectifier holds
    {4'd4,  10'b1001001_010},  // R4 over-current again: no pulse
    {4'd4,  10'b1001000_000},  // R4 clean start: low off, wait
    {4'd2,  10'b1000000_000},  // R2 no sense yet: high stays off
    {4'd2,  10'b1000010_100},  // R2 sense: high on
    {4'd1,  10'b1000000_100},  // R1 high holds
    {4'd1,  10'b1001000_100},  // R1 start ignored while high on
    {4'd3,  10'b1000100_000},  // R3 pwm off: dead edge 0
    {4'd3,  10'b1000000_000},  // R3 dead edge 1
    {4'd3,  10'b1000000_000},  // R3 dead edge 2
    {4'd3,  10'b1000000_010},  // R3 low on at edge 3
    {4'd4,  10'b1001000_000},  // R4 start: wait
    {4'd9,  10'b1000110_010},  // R9 cancel beats sense
    {4'd4,  10'b1001000_000},  // R4 start: wait
    {4'd2,  10'b1000010_100},  // R2 high on
    {4'd5,  10'b1100000_000},  // R5 undervoltage while high on
    {4'd5,  10'b1000000_000},  // R5 idle keeps both low
    {4'd4,  10'b1001000_000},  // R4 start from idle
    {4'd2,  10'b1000010_100},  // R2 high on
    {4'd6,  10'b1010000_000},  // R6 thermal while high on
    {4'd6,  10'b1001000_000},  // R6 restart after thermal clears
    {4'd2,  10'b1000010_100},  // R2 high on
    {4'd7,  10'b0000000_000},  // R7 disable while high on
    {4'd7,  10'b0001000_000},  // R7 start ignored while disabled
    {4'd7,  10'b1001001_010}   // R7 re-enabled start works
  };

  task automatic set_in(input logic [6:0] v);
    {en, uvlo, therm, cyc_start, pwm_off, lo_off_sense, valley_oc} = v;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect3(input int req, input logic [2:0] exp);
    checks++;
    if ({gate_hi, gate_lo, sense_fault} !== exp) begin
      errors++;
      $display("FAIL R%0d: {hi,lo,fault} actual=%b expected=%b",
               req, {gate_hi, gate_lo, sense_fault}, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R0: watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    set_in(7'b1000000);
    step();
    step();
    expect3(10, 3'b000);  // R10 reset state
    rst = 1'b0;
    step();
    expect3(10, 3'b000);  // R10 idle stays low without start

    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i][9:3]);
      step();
      expect3(int'(VEC[i][13:10]), VEC[i][2:0]);
      checks++;
      if (gate_hi && gate_lo) begin  // R1 shoot-through check
        errors++;
        $display("FAIL R1: hi=%b lo=%b expected not both high",
                 gate_hi, gate_lo);
      end
    end

    // R8: sense timeout. Enter wait, then 63 quiet edges, then fault.
    set_in(7'b1001000);
    step();
    expect3(8, 3'b000);
    set_in(7'b1000000);
    for (int k = 0; k < 63; k++) step();
    expect3(8, 3'b000);  // R8 one edge before timeout
    step();
    expect3(8, 3'b001);  // R8 fault raised
    set_in(7'b1001010);
    step();
    expect3(8, 3'b001);  // R8 sense and start ignored in fault
    set_in(7'b0000000);
    step();
    expect3(7, 3'b000);  // R7 disable clears fault

    // R10: reset in the middle of a high-side pulse
    set_in(7'b1001000);
    step();
    set_in(7'b1000010);
    step();
    expect3(2, 3'b100);
    set_in(7'b1000000);
    rst = 1'b1;
    step();
    expect3(10, 3'b000);  // R10 reset drops the pulse
    rst = 1'b0;
    step();
    expect3(10, 3'b000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule